// File: doc/BRIEF.md
# Processor Fault Status Register with Kernel Stack Guard

This block keeps a sticky record of why the processor last aborted or trapped. It also watches every kernel-mode stack push and compares the stack address against two limits. A push that lands just under the upper limit is legal but raises a warning trap. A push that lands below the lower limit raises a fatal abort.

A kernel stack push can also fail because of an addressing fault. In that case the fault is escalated: the abort line is raised and the stack-abort bit is recorded next to the fault's own cause bit. Software reads the register through a simple register-bus port and clears it by writing any value.

The trap and abort request lines are combinational and valid in the same cycle as the push. The recorded bits appear in the register one clock later.

Top module: `fault_status_reg`

## Requirements
- R1: Any register write (`reg_wr` high) clears the whole register to zero on the next clock edge, whatever `reg_wdata` holds. A write wins over fault events in the same cycle.
- R2: Bit encoding of the register: bit 7 (octal 000200) halt outside kernel mode, bit 6 (000100) odd address or MMU abort, bit 5 (000040) non-existent memory, bit 4 (000020) I/O bus timeout, bit 3 (000010) stack warning, bit 2 (000004) stack abort.
- R3: A halt event sets only bit 7 and raises neither request line.
- R4: A kernel push to an address from octal 340 to 377 raises `yel_trap` in the same cycle, records only bit 3 and does not raise `red_abort`.
- R5: A kernel push to an address below octal 340 raises `red_abort` in the same cycle and records bit 2.
- R6: A kernel push that fails with an odd address, non-existent memory or a bus timeout raises `red_abort` and records the cause bit plus bit 2, giving 000104, 000044 or 000024.
- R7: A kernel push that the MMU aborts raises `red_abort` and records 000104.
- R8: Outside a kernel push, no stack check applies. Odd-address, non-existent-memory and timeout events record only their own bit and raise no request line, and an MMU abort records nothing.
- R9: `red_abort` has priority over `yel_trap`. A push in the warning zone that also faults raises only the abort and leaves bit 3 clear.
- R10: A vector push in the warning zone records bit 3 but does not raise `yel_trap`.
- R11: Bits are sticky. Events OR into the register and never clear other bits.
- R12: `reg_rdata` returns the register value while `reg_rd` is high and zero otherwise. Bits 15:8 and 1:0 always read zero.
- R13: Reset clears the register and both request lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_halt_nk | input | 1 | Halt attempted outside kernel mode |
| ev_odd_addr | input | 1 | Odd-address access fault |
| ev_nxm | input | 1 | Non-existent memory fault |
| ev_bus_to | input | 1 | I/O bus timeout |
| ev_mmu_abort | input | 1 | MMU abort of the current access |
| push_act | input | 1 | Current access is a stack push |
| push_addr | input | 16 | Effective stack address of the push |
| kern_mode | input | 1 | Processor is in kernel mode |
| vec_push | input | 1 | Push belongs to an interrupt or trap vector sequence |
| reg_wr | input | 1 | Register write strobe (clears) |
| reg_wdata | input | 16 | Write data (ignored) |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 16 | Read data |
| err_q | output | 16 | Current register value |
| yel_trap | output | 1 | Stack warning trap request |
| red_abort | output | 1 | Stack abort request |

## Verification
The bench sweeps push addresses across both zone boundaries: octal 400, 376, 340 and 336. This separates the no-check, warning and abort cases, and an off-by-one in either limit comparison shows up there.

Each bus fault is applied twice, once during a kernel push and once outside any push. The expected codes differ (escalated or plain), so a missing escalation or a spurious stack bit is exposed.

Further patterns cover:
- a user-mode push below both limits;
- a vector push in the warning zone;
- a faulting warning-zone push;
- a write that coincides with an event.

These show whether the mode qualifier, the trap suppression, the abort priority and the write priority are each wired as required.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   localparam int unsigned FSR_BIT_HALT = 7;
   localparam int unsigned FSR_BIT_ODD  = 6;
   localparam int unsigned FSR_BIT_NXM  = 5;
   localparam int unsigned FSR_BIT_BTO  = 4;
   localparam int unsigned FSR_BIT_YEL  = 3;
   localparam int unsigned FSR_BIT_RED  = 2;
   localparam int unsigned FSR_MASK_W   = 8;

   typedef struct packed {
      logic halt_nk;
      logic odd_addr;
      logic nxm;
      logic bus_to;
      logic mmu_abort;
   } fsr_evt_t;

   typedef struct packed {
      logic in_red;
      logic in_yel;
      logic kpush;
   } fsr_zone_t;

endpackage

// File: rtl/fsr_zone_cmp.sv
module fsr_zone_cmp
   import fsr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned RED_LIM = 224,
   parameter int unsigned YEL_LIM = 256
) (
   input  logic              push_act,
   input  logic              kern_mode,
   input  logic [ADDR_W-1:0] addr,
   output fsr_zone_t         zone
);

   localparam logic [ADDR_W-1:0] RED_L = ADDR_W'(RED_LIM);
   localparam logic [ADDR_W-1:0] YEL_L = ADDR_W'(YEL_LIM);

   logic kpush;
   logic below_red;
   logic below_yel;

   always_comb begin
      kpush     = push_act & kern_mode;
      below_red = (addr < RED_L);
      below_yel = (addr < YEL_L);
      zone.kpush  = kpush;
      zone.in_red = kpush & below_red;
      zone.in_yel = kpush & below_yel & ~below_red;
   end

endmodule

// File: rtl/fsr_escalate.sv
module fsr_escalate
   import fsr_pkg::*;
#(
   parameter bit SUPPRESS_VEC_YEL = 1'b1
) (
   input  fsr_evt_t              evt,
   input  fsr_zone_t             zone,
   input  logic                  vec_push,
   output logic [FSR_MASK_W-1:0] set_mask,
   output logic                  red_req,
   output logic                  yel_req
);

   logic push_fault;
   logic yel_zone_ok;
   logic yel_raw;

   always_comb begin
      push_fault  = zone.kpush & (evt.odd_addr | evt.nxm | evt.bus_to | evt.mmu_abort);
      red_req     = zone.in_red | push_fault;
      yel_zone_ok = zone.in_yel & ~red_req;

      set_mask               = '0;
      set_mask[FSR_BIT_HALT] = evt.halt_nk;
      set_mask[FSR_BIT_ODD]  = evt.odd_addr | (push_fault & evt.mmu_abort);
      set_mask[FSR_BIT_NXM]  = evt.nxm;
      set_mask[FSR_BIT_BTO]  = evt.bus_to;
      set_mask[FSR_BIT_YEL]  = yel_zone_ok;
      set_mask[FSR_BIT_RED]  = red_req;
   end

   generate
      if (SUPPRESS_VEC_YEL) begin : g_vec_quiet
         always_comb yel_raw = yel_zone_ok & ~vec_push;
      end else begin : g_vec_loud
         always_comb yel_raw = yel_zone_ok;
      end
   endgenerate

   assign yel_req = yel_raw;

endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
   import fsr_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic [FSR_MASK_W-1:0] set_mask,
   output logic [DATA_W-1:0]     q
);

   localparam int unsigned HI_W = DATA_W - FSR_MASK_W;

   logic [FSR_MASK_W-1:0] bits_q;
   logic [FSR_MASK_W-1:0] bits_d;

   always_comb begin
      if (clr) bits_d = '0;
      else     bits_d = bits_q | set_mask;
      bits_d[1:0] = 2'b00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_d;
   end

   generate
      if (HI_W > 0) begin : g_pad
         assign q = {{HI_W{1'b0}}, bits_q};
      end else begin : g_nopad
         assign q = bits_q;
      end
   endgenerate

endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
   import fsr_pkg::*;
#(
   parameter int unsigned DATA_W           = 16,
   parameter int unsigned ADDR_W           = 16,
   parameter int unsigned RED_LIM          = 224,
   parameter int unsigned YEL_LIM          = 256,
   parameter bit          SUPPRESS_VEC_YEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_halt_nk,
   input  logic              ev_odd_addr,
   input  logic              ev_nxm,
   input  logic              ev_bus_to,
   input  logic              ev_mmu_abort,
   input  logic              push_act,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              kern_mode,
   input  logic              vec_push,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] err_q,
   output logic              yel_trap,
   output logic              red_abort
);

   initial begin
      if (DATA_W < FSR_MASK_W)
         $error("fault_status_reg: DATA_W must be at least %0d", FSR_MASK_W);
      if (YEL_LIM <= RED_LIM)
         $error("fault_status_reg: YEL_LIM must exceed RED_LIM");
      if (YEL_LIM >= (64'd1 << ADDR_W))
         $error("fault_status_reg: YEL_LIM does not fit ADDR_W");
   end

   fsr_evt_t              evt;
   fsr_zone_t             zone;
   logic [FSR_MASK_W-1:0] set_mask;
   logic                  red_req;
   logic                  yel_req;
   logic [DATA_W-1:0]     q;
   logic                  wr_unused;

   always_comb begin
      evt.halt_nk   = ev_halt_nk;
      evt.odd_addr  = ev_odd_addr;
      evt.nxm       = ev_nxm;
      evt.bus_to    = ev_bus_to;
      evt.mmu_abort = ev_mmu_abort;
   end

   assign wr_unused = ^reg_wdata;

   fsr_zone_cmp #(
      .ADDR_W  (ADDR_W),
      .RED_LIM (RED_LIM),
      .YEL_LIM (YEL_LIM)
   ) u_zone (
      .push_act  (push_act),
      .kern_mode (kern_mode),
      .addr      (push_addr),
      .zone      (zone)
   );

   fsr_escalate #(
      .SUPPRESS_VEC_YEL (SUPPRESS_VEC_YEL)
   ) u_esc (
      .evt      (evt),
      .zone     (zone),
      .vec_push (vec_push),
      .set_mask (set_mask),
      .red_req  (red_req),
      .yel_req  (yel_req)
   );

   fsr_status_reg #(
      .DATA_W (DATA_W)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (reg_wr),
      .set_mask (set_mask),
      .q        (q)
   );

   assign err_q     = q;
   assign reg_rdata = reg_rd ? q : '0;
   assign yel_trap  = rst_n & yel_req;
   assign red_abort = rst_n & red_req;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              kern_mode,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [DATA_W-1:0] err_q,
   input logic              yel_trap,
   input logic              red_abort
);

   p_wr_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (err_q == '0));

   p_yel_records_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (yel_trap && !reg_wr) |=> err_q[3]);

   p_red_records_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (red_abort && !reg_wr) |=> err_q[2]);

   p_user_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !kern_mode |-> (!yel_trap && !red_abort));

   p_red_over_yel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(yel_trap && red_abort));

   p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ((err_q & $past(err_q)) == $past(err_q)));

   p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[DATA_W-1:8] == '0) && (err_q[1:0] == 2'b00));

   p_read_path_r12: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> (reg_rdata == err_q));

endmodule

bind fault_status_reg fsr_checker #(.DATA_W(DATA_W)) u_fsr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .kern_mode (kern_mode),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_rdata (reg_rdata),
   .err_q     (err_q),
   .yel_trap  (yel_trap),
   .red_abort (red_abort)
);

// File: tb/fault_status_reg_bench.sv
module fault_status_reg_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ev_halt_nk, ev_odd_addr, ev_nxm, ev_bus_to, ev_mmu_abort;
   logic        push_act, kern_mode, vec_push;
   logic [15:0] push_addr;
   logic        reg_wr, reg_rd;
   logic [15:0] reg_wdata;
   logic [15:0] reg_rdata, err_q;
   logic        yel_trap, red_abort;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   fault_status_reg u_fault_status_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .ev_halt_nk   (ev_halt_nk),
      .ev_odd_addr  (ev_odd_addr),
      .ev_nxm       (ev_nxm),
      .ev_bus_to    (ev_bus_to),
      .ev_mmu_abort (ev_mmu_abort),
      .push_act     (push_act),
      .push_addr    (push_addr),
      .kern_mode    (kern_mode),
      .vec_push     (vec_push),
      .reg_wr       (reg_wr),
      .reg_wdata    (reg_wdata),
      .reg_rd       (reg_rd),
      .reg_rdata    (reg_rdata),
      .err_q        (err_q),
      .yel_trap     (yel_trap),
      .red_abort    (red_abort)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%06o expected=%06o", tag, act, exp);
      end
   endtask

   task automatic idle();
      ev_halt_nk = 0; ev_odd_addr = 0; ev_nxm = 0; ev_bus_to = 0; ev_mmu_abort = 0;
      push_act = 0; kern_mode = 0; vec_push = 0; push_addr = 16'o001000;
      reg_wr = 0; reg_rd = 0; reg_wdata = 0;
   endtask

   // events are driven at a falling edge; request lines checked before the rising edge,
   // the register after it at the next falling edge
   task automatic cycle_chk(input string tag, input logic exp_y, input logic exp_r,
                            input logic [15:0] exp_q);
      #2;
      chk({tag, " yel_trap"}, {15'd0, yel_trap}, {15'd0, exp_y});
      chk({tag, " red_abort"}, {15'd0, red_abort}, {15'd0, exp_r});
      @(posedge clk); @(negedge clk);
      idle();
      chk({tag, " err_q"}, err_q, exp_q);
   endtask

   task automatic clear_reg(input logic [15:0] data);
      reg_wr = 1; reg_wdata = data;
      @(posedge clk); @(negedge clk);
      idle();
   endtask

   task automatic push(input logic [15:0] a, input logic k, input logic v);
      push_act = 1; push_addr = a; kern_mode = k; vec_push = v;
   endtask

   task automatic t_reset();
      chk("R13 reset err_q", err_q, 16'o0);
      chk("R13 reset yel", {15'd0, yel_trap}, 16'd0);
      chk("R13 reset red", {15'd0, red_abort}, 16'd0);
   endtask

   task automatic t_halt();
      ev_halt_nk = 1;
      cycle_chk("R3 R2 halt", 0, 0, 16'o000200);
      clear_reg(16'o177777);
      chk("R1 clear all-ones", err_q, 16'o0);
   endtask

   task automatic t_zones();
      push(16'o000400, 1, 0);
      cycle_chk("R4 addr 400 no check", 0, 0, 16'o0);
      push(16'o000376, 1, 0);
      cycle_chk("R4 yellow 376", 1, 0, 16'o000010);
      clear_reg(16'o000004);
      chk("R1 clear red-only data", err_q, 16'o0);
      push(16'o000340, 1, 0);
      cycle_chk("R4 yellow 340", 1, 0, 16'o000010);
      clear_reg(16'o0);
      push(16'o000336, 1, 0);
      cycle_chk("R5 red 336", 0, 1, 16'o000004);
      clear_reg(~16'o000004);
      chk("R1 clear complement", err_q, 16'o0);
   endtask

   task automatic t_escalate();
      push(16'o001001, 1, 0); ev_odd_addr = 1;
      cycle_chk("R6 odd push", 0, 1, 16'o000104);
      clear_reg(0);
      push(16'o140004, 1, 0); ev_nxm = 1;
      cycle_chk("R6 nxm push", 0, 1, 16'o000044);
      clear_reg(0);
      push(16'o160004, 1, 0); ev_bus_to = 1;
      cycle_chk("R6 timeout push", 0, 1, 16'o000024);
      clear_reg(0);
      push(16'o140004, 1, 0); ev_mmu_abort = 1;
      cycle_chk("R7 mmu push", 0, 1, 16'o000104);
      clear_reg(0);
   endtask

   task automatic t_nonpush();
      kern_mode = 1; ev_odd_addr = 1;
      cycle_chk("R8 odd no push", 0, 0, 16'o000100);
      clear_reg(0);
      kern_mode = 1; ev_nxm = 1;
      cycle_chk("R8 nxm no push", 0, 0, 16'o000040);
      clear_reg(0);
      kern_mode = 1; ev_bus_to = 1;
      cycle_chk("R8 timeout no push", 0, 0, 16'o000020);
      clear_reg(0);
      kern_mode = 1; ev_mmu_abort = 1;
      cycle_chk("R8 mmu no push", 0, 0, 16'o000000);
      push(16'o000100, 0, 0);
      cycle_chk("R8 user push low", 0, 0, 16'o000000);
   endtask

   task automatic t_priority();
      push(16'o000377, 1, 0); ev_odd_addr = 1;
      cycle_chk("R9 yellow+odd", 0, 1, 16'o000104);
      clear_reg(0);
      push(16'o000370, 1, 1);
      cycle_chk("R10 vector push yellow", 0, 0, 16'o000010);
      clear_reg(0);
   endtask

   task automatic t_sticky_read();
      ev_halt_nk = 1;
      cycle_chk("R11 step1", 0, 0, 16'o000200);
      ev_bus_to = 1;
      cycle_chk("R11 step2", 0, 0, 16'o000220);
      push(16'o000350, 1, 0);
      cycle_chk("R11 step3", 1, 0, 16'o000230);
      chk("R12 rdata idle", reg_rdata, 16'o0);
      reg_rd = 1; #1;
      chk("R12 rdata read", reg_rdata, 16'o000230);
      reg_rd = 0;
      reg_wr = 1; ev_nxm = 1;
      @(posedge clk); @(negedge clk); idle();
      chk("R1 write beats event", err_q, 16'o0);
   endtask

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_halt();
      t_zones();
      t_escalate();
      t_nonpush();
      t_priority();
      t_sticky_read();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule